// File: doc/BRIEF.md
# Load-Store Alignment Fault Checker

This block sits in the memory stage of a small 32-bit processor. Each accepted load or store request carries an address, an access size, an instruction class and a global trap-enable bit. The block decides whether the access is naturally aligned and whether the instruction class may complete an unaligned access. It then either raises a one-cycle usage fault or drives the access onto the bus as one or two aligned beats.

For a split load, the block collects both read beats and rotates the bytes into a little-endian result. A halfword result is zero- or sign-extended according to the class. A busy output holds off new requests until the sequence ends, and a done strobe marks the cycle in which the merged read data is valid.

Size codes are 0 byte, 1 halfword, 2 word, 3 dual word and 4 multiple word. Class codes 0..5 are the classes that may complete unaligned: plain word, halfword and signed halfword, followed by the unprivileged word, halfword and signed halfword. Codes 6 and 7 cover every other load or store class. For dual and multiple word accesses the block handles only the first word; issuing any further words is the caller's job.

Top module: `lsu_align_unit`

## Requirements
- R1: The alignment rules are as follows. Sizes 2, 3 and 4 are aligned only when address bits [1:0] are 0. Size 1 is aligned only when address bit 0 is 0. Size 0 is always aligned and never faults.
- R2: With `trap_unaligned` low, an unaligned access of class 0..5 proceeds on the bus. An unaligned access of class 6 or 7 faults.
- R3: With `trap_unaligned` high, every unaligned access faults, whatever its class. Aligned accesses still proceed.
- R4: A faulting request produces no bus beat. `fault` is high for exactly one cycle, the cycle after acceptance, with `fault_addr` equal to the request address.
- R5: A permitted unaligned word access with offset o = addr[1:0] is issued as two beats on consecutive cycles. The lower word address comes first with `bus_be` = 4'b1111 << o. The next word address follows with `bus_be` = 4'b1111 >> (4-o).
- R6: A permitted unaligned halfword at offset 1 is a single beat with `bus_be` 4'b0110. At offset 3 it is two beats, with enables 4'b1000 and then 4'b0001.
- R7: An aligned access, or any byte access, is a single beat at the word-aligned address. Its enables are 4'b0001 << o for a byte, 4'b0011 << o for a halfword, and 4'b1111 otherwise.
- R8: For stores, byte i of `req_wdata` appears on the lane of address addr+i, in the beat that covers that address. `bus_we` follows the store bit.
- R9: For loads, `rd_data` holds the bytes at addr, addr+1, ... in little-endian order. Byte results are zero-extended. Halfword results are sign-extended from bit 15 for classes 2 and 5 and zero-extended otherwise.
- R10: Bus beats begin the cycle after acceptance. `done` pulses the cycle after the last beat. `busy` is high from the cycle after acceptance through the done or fault cycle, and requests presented while busy have no effect.
- R11: A synchronous active-high reset returns the block to idle, even in the middle of a split access. After reset `busy`, `bus_valid`, `fault` and `done` are low, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 3 | Size code (0 byte .. 4 multiple word) |
| req_class | input | 3 | Instruction class code (0..5 may split, 6..7 may not) |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | DW | Store data, least significant byte at the request address |
| trap_unaligned | input | 1 | Fault on every unaligned access |
| busy | output | 1 | Sequence in progress; new requests ignored |
| bus_valid | output | 1 | A bus beat is presented this cycle |
| bus_addr | output | AW | Word-aligned beat address |
| bus_be | output | DW/8 | Byte-lane enables of the beat |
| bus_we | output | 1 | Beat is a write |
| bus_wdata | output | DW | Lane-positioned write data |
| bus_rdata | input | DW | Read data returned in the beat cycle |
| done | output | 1 | Access complete; `rd_data` valid |
| rd_data | output | DW | Merged and extended load result |
| fault | output | 1 | One-cycle usage-fault pulse |
| fault_addr | output | AW | Address of the faulting access |

## Verification
The bench builds the block with its defaults, AW = 32 and DW = 32. These give four byte lanes, so every offset 0..3 meets every size code, and both split cases can be reached: the word crossing and the halfword crossing at offset 3. The full 32-bit address lets one split word sit at the top of the address space, so its second beat wraps to address 0. Sweeping the classes across each trap setting exposes both fault causes and the extension choice for halfword loads.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [2:0] {
      SZ_BYTE  = 3'd0,
      SZ_HALF  = 3'd1,
      SZ_WORD  = 3'd2,
      SZ_DUAL  = 3'd3,
      SZ_MULTI = 3'd4
   } acc_size_e;

   typedef enum logic [2:0] {
      CL_WORD    = 3'd0,
      CL_HALF    = 3'd1,
      CL_SHALF   = 3'd2,
      CL_WORD_U  = 3'd3,
      CL_HALF_U  = 3'd4,
      CL_SHALF_U = 3'd5,
      CL_OTHER_A = 3'd6,
      CL_OTHER_B = 3'd7
   } acc_class_e;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_FAULT = 3'd1,
      SQ_BEAT0 = 3'd2,
      SQ_BEAT1 = 3'd3,
      SQ_DONE  = 3'd4
   } seq_state_e;

   // classes allowed to complete an access that is not naturally aligned
   function automatic logic class_may_split(input logic [2:0] c);
      return (c <= CL_SHALF_U);
   endfunction

   function automatic logic class_signed(input logic [2:0] c);
      return (c == CL_SHALF) || (c == CL_SHALF_U);
   endfunction

endpackage

// File: rtl/lsu_align_decode.sv
module lsu_align_decode
   import lsu_align_pkg::*;
#(
   parameter int LANES = 4,
   localparam int OW = $clog2(LANES)
) (
   input  logic [OW-1:0]    offset,
   input  logic [2:0]       size,
   input  logic [2:0]       cls,
   input  logic             trap,
   output logic             aligned,
   output logic             fault,
   output logic             two_beat,
   output logic [LANES-1:0] be_lo,
   output logic [LANES-1:0] be_hi
);

   logic [2*LANES-1:0] ones;
   logic [2*LANES-1:0] span;

   always_comb begin
      ones = '0;
      case (size)
         SZ_BYTE: begin
            ones[0] = 1'b1;
            aligned = 1'b1;
         end
         SZ_HALF: begin
            ones[1:0] = 2'b11;
            aligned   = ~offset[0];
         end
         default: begin
            ones[LANES-1:0] = '1;
            aligned         = (offset == '0);
         end
      endcase
   end

   assign span     = ones << offset;
   assign be_lo    = span[LANES-1:0];
   assign be_hi    = span[2*LANES-1:LANES];
   assign two_beat = |be_hi;
   assign fault    = ~aligned & (trap | ~class_may_split(cls));

endmodule

// File: rtl/lsu_align_merge.sv
module lsu_align_merge
   import lsu_align_pkg::*;
#(
   parameter int DW = 32,
   localparam int LANES = DW / 8,
   localparam int OW = $clog2(LANES)
) (
   input  logic [DW-1:0] rd_lo,
   input  logic [DW-1:0] rd_hi,
   input  logic [OW-1:0] offset,
   input  logic [2:0]    size,
   input  logic          sign_ext,
   output logic [DW-1:0] data
);

   logic [2*DW-1:0] cat;
   logic [DW-1:0]   rot;

   assign cat = {rd_hi, rd_lo};

   // lane i of the result takes byte (i + offset) of the two-beat window
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign rot[i*8 +: 8] = cat[(i*8 + 32'(offset) * 8) +: 8];
   end

   always_comb begin
      case (size)
         SZ_BYTE: data = DW'(rot[7:0]);
         SZ_HALF: data = sign_ext ? {{(DW-16){rot[15]}}, rot[15:0]} : DW'(rot[15:0]);
         default: data = rot;
      endcase
   end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
   import lsu_align_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_addr,
   input  logic [2:0]      req_size,
   input  logic [2:0]      req_class,
   input  logic            req_store,
   input  logic [DW-1:0]   req_wdata,
   input  logic            trap_unaligned,
   output logic            busy,
   output logic            bus_valid,
   output logic [AW-1:0]   bus_addr,
   output logic [DW/8-1:0] bus_be,
   output logic            bus_we,
   output logic [DW-1:0]   bus_wdata,
   input  logic [DW-1:0]   bus_rdata,
   output logic            done,
   output logic [DW-1:0]   rd_data,
   output logic            fault,
   output logic [AW-1:0]   fault_addr
);

   localparam int LANES = DW / 8;
   localparam int OW    = $clog2(LANES);

   if (DW < 32 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("lsu_align_unit: DW must be a power of two of at least 32");
   end
   if (AW <= OW) begin : g_bad_aw
      $error("lsu_align_unit: AW too narrow for the lane offset");
   end

   seq_state_e       state;
   logic [AW-1:0]    r_addr;
   logic [2:0]       r_size;
   logic [2:0]       r_cls;
   logic             r_store;
   logic [DW-1:0]    r_wdata;
   logic             r_two;
   logic [LANES-1:0] r_be_lo, r_be_hi;
   logic [DW-1:0]    r_rd_lo, r_rd_hi;

   logic             dec_aligned, dec_fault, dec_two;
   logic [LANES-1:0] dec_be_lo, dec_be_hi;

   lsu_align_decode #(.LANES(LANES)) u_decode (
      .offset   (req_addr[OW-1:0]),
      .size     (req_size),
      .cls      (req_class),
      .trap     (trap_unaligned),
      .aligned  (dec_aligned),
      .fault    (dec_fault),
      .two_beat (dec_two),
      .be_lo    (dec_be_lo),
      .be_hi    (dec_be_hi)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= SQ_IDLE;
         r_addr  <= '0;
         r_size  <= '0;
         r_cls   <= '0;
         r_store <= 1'b0;
         r_wdata <= '0;
         r_two   <= 1'b0;
         r_be_lo <= '0;
         r_be_hi <= '0;
         r_rd_lo <= '0;
         r_rd_hi <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (req_valid) begin
                  r_addr  <= req_addr;
                  r_size  <= req_size;
                  r_cls   <= req_class;
                  r_store <= req_store;
                  r_wdata <= req_wdata;
                  r_two   <= dec_two;
                  r_be_lo <= dec_be_lo;
                  r_be_hi <= dec_be_hi;
                  r_rd_hi <= '0;
                  state   <= dec_fault ? SQ_FAULT : SQ_BEAT0;
               end
            end
            SQ_BEAT0: begin
               r_rd_lo <= bus_rdata;
               state   <= r_two ? SQ_BEAT1 : SQ_DONE;
            end
            SQ_BEAT1: begin
               r_rd_hi <= bus_rdata;
               state   <= SQ_DONE;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   logic [AW-1:0]   base_addr;
   logic [2*DW-1:0] wshift;
   logic            second;

   assign second    = (state == SQ_BEAT1);
   assign base_addr = {r_addr[AW-1:OW], {OW{1'b0}}};
   assign wshift    = {{DW{1'b0}}, r_wdata} << (32'(r_addr[OW-1:0]) * 8);

   assign busy       = (state != SQ_IDLE);
   assign bus_valid  = (state == SQ_BEAT0) || second;
   assign bus_addr   = second ? base_addr + AW'(LANES) : base_addr;
   assign bus_be     = second ? r_be_hi : r_be_lo;
   assign bus_we     = r_store;
   assign bus_wdata  = second ? wshift[2*DW-1:DW] : wshift[DW-1:0];
   assign done       = (state == SQ_DONE);
   assign fault      = (state == SQ_FAULT);
   assign fault_addr = r_addr;

   lsu_align_merge #(.DW(DW)) u_merge (
      .rd_lo    (r_rd_lo),
      .rd_hi    (r_rd_hi),
      .offset   (r_addr[OW-1:0]),
      .size     (r_size),
      .sign_ext (class_signed(r_cls)),
      .data     (rd_data)
   );

   logic unused_aligned;
   assign unused_aligned = dec_aligned;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            busy,
   input logic            bus_valid,
   input logic [AW-1:0]   bus_addr,
   input logic [DW/8-1:0] bus_be,
   input logic            done,
   input logic            fault
);

   localparam int LANES = DW / 8;
   localparam int OW    = $clog2(LANES);

   // R4: a fault never coincides with a bus beat
   a_r4_fault_no_beat: assert property (@(posedge clk) disable iff (rst)
      fault |-> !bus_valid);

   // R4: the fault pulse lasts one cycle
   a_r4_fault_one_cycle: assert property (@(posedge clk) disable iff (rst)
      fault |=> !fault);

   // R5: back-to-back beats step up by one word
   a_r5_beats_ascend: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_valid) && bus_valid) |-> (bus_addr == $past(bus_addr) + AW'(LANES)));

   // R6: a second beat always starts at lane 0
   a_r6_second_beat_lane0: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_valid) && bus_valid) |-> bus_be[0]);

   // R7: beats are word aligned and enable at least one lane
   a_r7_beat_aligned: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> (bus_addr[OW-1:0] == '0 && bus_be != '0));

   // R10: any activity is covered by busy
   a_r10_busy_covers: assert property (@(posedge clk) disable iff (rst)
      (bus_valid || fault || done) |-> busy);

   // R10: done follows the last beat directly
   a_r10_done_after_beat: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(bus_valid));

   // R11: reset leaves the block idle
   a_r11_reset_idle: assert property (@(posedge clk)
      rst |=> (!busy && !bus_valid && !fault && !done));

endmodule

bind lsu_align_unit lsu_align_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .busy      (busy),
   .bus_valid (bus_valid),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .done      (done),
   .fault     (fault)
);

// File: tb/lsu_align_unit_test.sv
`timescale 1ns/1ps
module lsu_align_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [2:0]  req_class = '0;
   logic        req_store = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        trap_unaligned = 1'b0;
   logic        busy, bus_valid, bus_we, done, fault;
   logic [31:0] bus_addr, bus_wdata, bus_rdata, rd_data, fault_addr;
   logic [3:0]  bus_be;

   int n_checks = 0;
   int n_fail   = 0;
   bit mon_on   = 1'b0;

   always #2 clk = ~clk;

   lsu_align_unit uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_class(req_class), .req_store(req_store),
      .req_wdata(req_wdata), .trap_unaligned(trap_unaligned), .busy(busy),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .done(done), .rd_data(rd_data), .fault(fault), .fault_addr(fault_addr)
   );

   // memory model: every byte address has a fixed pseudo-random content
   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
   endfunction

   assign bus_rdata = {mem_byte(bus_addr + 32'd3), mem_byte(bus_addr + 32'd2),
                       mem_byte(bus_addr + 32'd1), mem_byte(bus_addr)};

   typedef struct packed {
      bit          busy;
      bit          valid;
      bit          we;
      bit          fault;
      bit          done;
      bit          chk_rd;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [31:0] faddr;
      logic [31:0] rdata;
      logic [3:0]  tag;
   } exp_t;

   exp_t expq[$];

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd1:  return "R1 R2";
         4'd2:  return "R1 R3";
         4'd4:  return "R4";
         4'd5:  return "R5";
         4'd6:  return "R6";
         4'd7:  return "R7";
         4'd8:  return "R8";
         4'd9:  return "R9";
         4'd11: return "R11";
         default: return "R10";
      endcase
   endfunction

   task automatic cmp(input string tg, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // per-cycle comparison against the expected queue
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on && !rst) begin
            exp_t e;
            logic [31:0] m;
            if (expq.size() > 0) e = expq.pop_front();
            else e = '{tag: 4'd10, default: '0};
            cmp("R10", "busy", 32'(busy), 32'(e.busy));
            cmp(e.fault ? "R4" : tag_name(e.tag), "bus_valid", 32'(bus_valid), 32'(e.valid));
            if (e.valid) begin
               cmp(tag_name(e.tag), "bus_addr", bus_addr, e.addr);
               cmp(tag_name(e.tag), "bus_be", 32'(bus_be), 32'(e.be));
               cmp("R8", "bus_we", 32'(bus_we), 32'(e.we));
               if (e.we) begin
                  m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
                  cmp("R8", "bus_wdata", bus_wdata & m, e.wdata & m);
               end
            end
            cmp(tag_name(e.tag), "fault", 32'(fault), 32'(e.fault));
            if (e.fault) cmp("R4", "fault_addr", fault_addr, e.faddr);
            cmp("R10", "done", 32'(done), 32'(e.done));
            if (e.done && e.chk_rd) cmp("R9", "rd_data", rd_data, e.rdata);
         end
      end
   end

   // behavioural model of one request, then drive it; hold keeps junk on the inputs while busy
   task automatic issue(input logic [31:0] a, input int sz, input int cl, input bit st,
                        input logic [31:0] wd, input bit tr, input bit hold);
      int          n;
      bit          al, flt;
      logic [3:0]  be[2];
      logic [31:0] wb[2];
      logic [31:0] rv;
      int          nb;
      exp_t        e;
      n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      al = (sz == 0) || ((sz == 1) ? (a[0] == 1'b0) : (a[1:0] == 2'b00));
      flt = !al && (tr || cl > 5);
      if (flt) begin
         e = '{busy: 1'b1, fault: 1'b1, faddr: a, tag: (tr ? 4'd2 : 4'd1), default: '0};
         expq.push_back(e);
      end else begin
         be[0] = '0; be[1] = '0; wb[0] = '0; wb[1] = '0; rv = '0; nb = 1;
         for (int i = 0; i < n; i++) begin
            logic [31:0] ba;
            int b;
            ba = a + 32'(i);
            b  = (ba[31:2] == a[31:2]) ? 0 : 1;
            if (b == 1) nb = 2;
            be[b][ba[1:0]] = 1'b1;
            wb[b][ba[1:0]*8 +: 8] = wd[i*8 +: 8];
            rv[i*8 +: 8] = mem_byte(ba);
         end
         if (sz == 1 && (cl == 2 || cl == 5)) rv[31:16] = {16{rv[15]}};
         for (int b = 0; b < nb; b++) begin
            e = '{busy: 1'b1, valid: 1'b1, we: st, be: be[b], wdata: wb[b],
                  addr: {a[31:2], 2'b00} + 32'(4 * b),
                  tag: (al ? 4'd7 : (sz == 1 ? 4'd6 : 4'd5)), default: '0};
            expq.push_back(e);
         end
         e = '{busy: 1'b1, done: 1'b1, chk_rd: !st, rdata: rv, tag: 4'd9, default: '0};
         expq.push_back(e);
      end
      req_valid      = 1'b1;
      req_addr       = a;
      req_size       = 3'(sz);
      req_class      = 3'(cl);
      req_store      = st;
      req_wdata      = wd;
      trap_unaligned = tr;
      @(negedge clk);
      if (hold) begin
         // R10: a second request presented while busy must not be taken
         req_addr  = a ^ 32'h0000_0103;
         req_size  = 3'd0;
         req_class = 3'd7;
         req_store = !st;
      end else begin
         req_valid = 1'b0;
      end
      while (expq.size() != 0) @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      n_checks++;
      $display("FAIL R10 watchdog: actual running expected finished");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11: reset state
      cmp("R11", "busy", 32'(busy), 32'd0);
      cmp("R11", "bus_valid", 32'(bus_valid), 32'd0);
      cmp("R11", "fault", 32'(fault), 32'd0);
      cmp("R11", "done", 32'(done), 32'd0);
      rst = 1'b0;
      mon_on = 1'b1;
      @(negedge clk);

      // directed corners
      issue(32'h0000_1001, 2, 0, 0, 32'h0, 0, 0);          // R5 split word load
      issue(32'h0000_2003, 1, 2, 0, 32'h0, 0, 0);          // R6 crossing signed half
      issue(32'h0000_2081, 1, 1, 1, 32'hA1B2C3D4, 0, 0);   // R6 inside word, store
      issue(32'h0000_3002, 2, 6, 0, 32'h0, 0, 0);          // R2 class fault
      issue(32'h0000_3002, 2, 0, 0, 32'h0, 1, 0);          // R3 trap fault
      issue(32'h0000_3004, 2, 0, 1, 32'h11223344, 1, 0);   // R3 aligned passes with trap
      issue(32'h0000_4007, 0, 7, 0, 32'h0, 1, 0);          // R1 byte never faults
      issue(32'h0000_5006, 3, 6, 0, 32'h0, 0, 0);          // R1 dual unaligned fault
      issue(32'hFFFF_FFFD, 2, 3, 1, 32'hCAFEF00D, 0, 0);   // R5 wrap of second beat
      issue(32'h0000_6002, 2, 0, 0, 32'h0, 0, 1);          // R10 ignore while busy
      issue(32'h0000_6103, 3, 7, 0, 32'h0, 0, 1);          // R10 ignore during fault

      // sweep of size x offset x class x trap x direction
      for (int sz = 0; sz < 5; sz++)
         for (int off = 0; off < 4; off++)
            for (int ci = 0; ci < 4; ci++)
               for (int tr = 0; tr < 2; tr++)
                  for (int st = 0; st < 2; st++) begin
                     int cl;
                     cl = (ci == 0) ? 0 : (ci == 1) ? 2 : (ci == 2) ? 4 : 6;
                     issue(32'h0001_0000 + 32'(sz * 64 + off + ci * 16 + tr * 4096),
                           sz, cl, st[0], 32'h8765_4321 ^ 32'(sz * 7 + off), tr[0], 0);
                  end

      // R11: reset in the middle of a split access
      mon_on = 1'b0;
      req_valid = 1'b1; req_addr = 32'h0000_7001; req_size = 3'd2;
      req_class = 3'd0; req_store = 1'b0; trap_unaligned = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      cmp("R11", "bus_valid before reset", 32'(bus_valid), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      cmp("R11", "busy", 32'(busy), 32'd0);
      cmp("R11", "bus_valid", 32'(bus_valid), 32'd0);
      rst = 1'b0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         cmp("R11", "done", 32'(done), 32'd0);
         cmp("R11", "busy", 32'(busy), 32'd0);
      end
      summary();
   end

endmodule